// File: doc/BRIEF.md
# DDC1 Serial Transmitter and Link Mode Controller

This block sends EDID bytes to a display host over a one-wire, transmit-only link in which the frame sync signal, VSYNC, serves as the bit clock. Each rising VSYNC edge puts the next bit on SDA. A frame is eight data bits, most significant bit first, followed by one released (null) bit. When the null bit goes out, a one-byte holding buffer is copied into the shift register. The buffer is then marked empty, and firmware must refill it once per nine VSYNC edges. SDA is open-drain: the block either pulls the line low or releases it.

The block also tracks the link mode. A low level on SCL means a host wants the two-wire bidirectional protocol. The block then leaves the transmit-only mode, stops shifting and releases SDA. The two-wire slave logic is outside this block and reports a matching device address. That report locks the mode until the soft-reset control is pulsed. Without an address match, 128 consecutive VSYNC rising edges seen while SCL stays high return the link to the transmit-only mode.

States: `LINK_DDC1` (transmit-only, shifting), `LINK_PROBE` (two-wire mode entered but no address matched yet), `LINK_LOCKED` (address matched). Transitions: DDC1 to PROBE on SCL low. PROBE to LOCKED on an address match. PROBE to DDC1 on the 128th counted VSYNC edge. Any state goes to DDC1 on reset or soft reset.

Top module: `ddc1_link_tx`

## Requirements
- R1: After reset, `link_mode_o` is 2'b00 (transmit-only), `ddc2b_o` is 0, `sda_pull_o` is 0 (line released) and `buf_empty_irq_o` is 1.
- R2: In transmit-only mode, each VSYNC rising edge presents the next data bit on SDA, most significant bit first. `sda_pull_o`=1 means the line is driven low, which is a 0 bit. The output is visible one clock after the edge is sampled.
- R3: The ninth edge of each frame presents a null bit, with SDA released (`sda_pull_o`=0).
- R4: On the ninth edge, the buffer byte is copied into the shift register and `buf_empty_irq_o` rises.
- R5: A buffer write (`buf_wr_i`=1 for one clock) clears `buf_empty_irq_o` on the next clock. A write on the same clock as a reload wins.
- R6: Before any byte has been written, buffer and shift register hold FFh, so SDA stays released across whole frames.
- R7: SCL low while in transmit-only mode moves `link_mode_o` to 2'b01 and sets `ddc2b_o` on the next clock. No interrupt is raised: `buf_empty_irq_o` is 0 whenever `ddc2b_o` is 1.
- R8: In mode 2'b01, 128 VSYNC rising edges counted while SCL is high return the mode to 2'b00. Any clock with SCL low restarts the count.
- R9: An address match in mode 2'b01 moves to mode 2'b10, which ignores VSYNC and SCL. The shifter holds its position while in either two-wire mode.
- R10: While `soft_rst_i` is 1, the block is held in its R1 state. After it is cleared, the transmit-only mode resumes with FFh frames.
- R11: In either two-wire mode, SDA is released (`sda_pull_o`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Synchronized VSYNC, bit clock of the one-wire link |
| scl_i | input | 1 | Synchronized two-wire bus clock level |
| buf_wr_i | input | 1 | One-clock strobe writing the holding buffer |
| buf_wdata_i | input | DATA_W | Byte written to the holding buffer |
| addr_valid_i | input | 1 | Address match reported by the two-wire slave |
| soft_rst_i | input | 1 | Level-held soft reset of the interface |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| buf_empty_irq_o | output | 1 | Buffer empty while in transmit-only mode |
| ddc2b_o | output | 1 | 1 in either two-wire mode |
| link_mode_o | output | 2 | 00 transmit-only, 01 two-wire unlocked, 10 two-wire locked |

## Verification
Assertions check a set of rules on every clock:
- SDA is released and the interrupt is quiet whenever a two-wire mode is active.
- SCL low in transmit-only mode enters the unlocked mode one clock later.
- The locked mode is sticky.
- Soft reset restores the transmit-only mode.
- A frame's ninth edge releases SDA and marks the buffer empty.
- A write clears the empty flag.
- The shifter output holds still without a VSYNC step.

Only the bench scenarios can show the rest: the exact bit order of a written byte, the 128-edge exit window and its restart on SCL low, and the FFh frames after reset or soft reset. For these, a queue-based reference model is compared with the outputs on every clock.

// File: rtl/ddc1_link_pkg.sv
package ddc1_link_pkg;
    typedef enum logic [1:0] {
        LINK_DDC1   = 2'b00,
        LINK_PROBE  = 2'b01,
        LINK_LOCKED = 2'b10
    } link_mode_e;
endpackage

// File: rtl/ddc1_vsync_edge.sv
module ddc1_vsync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_i,
    output logic rise_o
);
    logic vs_q;

    // Held high in reset so a level already high gives no edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vs_q <= 1'b1;
        else        vs_q <= vsync_i;
    end

    assign rise_o = vsync_i & ~vs_q;
endmodule

// File: rtl/ddc1_frame_shifter.sv
module ddc1_frame_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              step_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              tx_bit_o,
    output logic              empty_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] NULL_POS = CNT_W'(DATA_W);

    typedef enum logic {SH_DATA, SH_NULL} shift_phase_e;

    logic [DATA_W-1:0] buf_q, sh_q;
    logic [CNT_W-1:0]  pos_q;
    logic              tx_q, empty_q;
    shift_phase_e      phase;

    always_comb begin
        phase = (pos_q == NULL_POS) ? SH_NULL : SH_DATA;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q   <= '1;
            sh_q    <= '1;
            pos_q   <= '0;
            tx_q    <= 1'b1;
            empty_q <= 1'b1;
        end else if (clr_i) begin
            buf_q   <= '1;
            sh_q    <= '1;
            pos_q   <= '0;
            tx_q    <= 1'b1;
            empty_q <= 1'b1;
        end else begin
            if (step_i) begin
                unique case (phase)
                    SH_DATA: begin
                        tx_q  <= sh_q[DATA_W-1];
                        sh_q  <= {sh_q[DATA_W-2:0], 1'b1};
                        pos_q <= pos_q + 1'b1;
                    end
                    SH_NULL: begin
                        tx_q    <= 1'b1;
                        sh_q    <= buf_q;
                        pos_q   <= '0;
                        empty_q <= 1'b1;
                    end
                    default: pos_q <= '0;
                endcase
            end
            if (wr_i) begin
                buf_q   <= wdata_i;
                empty_q <= 1'b0;
            end
        end
    end

    assign tx_bit_o = tx_q;
    assign empty_o  = empty_q;

    p_null_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && phase == SH_NULL && !clr_i) |=> tx_bit_o);

    p_reload_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && phase == SH_NULL && !clr_i && !wr_i) |=> empty_o);

    p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> !empty_o);

    p_hold_without_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clr_i) |=> $stable(tx_bit_o));
endmodule

// File: rtl/ddc1_mode_fsm.sv
module ddc1_mode_fsm
    import ddc1_link_pkg::*;
#(
    parameter int EXIT_PULSES = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       scl_i,
    input  logic       rise_i,
    input  logic       addr_valid_i,
    output link_mode_e mode_o
);
    localparam int CNT_W = $clog2(EXIT_PULSES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(EXIT_PULSES - 1);

    link_mode_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINK_DDC1;
            cnt_q   <= '0;
        end else if (clr_i) begin
            state_q <= LINK_DDC1;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LINK_DDC1: begin
                cnt_d = '0;
                if (!scl_i) state_d = LINK_PROBE;
            end
            LINK_PROBE: begin
                if (addr_valid_i) begin
                    state_d = LINK_LOCKED;
                    cnt_d   = '0;
                end else if (!scl_i) begin
                    cnt_d = '0;
                end else if (rise_i) begin
                    if (cnt_q == LAST_CNT) begin
                        state_d = LINK_DDC1;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            LINK_LOCKED: cnt_d = '0;
            default: begin
                state_d = LINK_DDC1;
                cnt_d   = '0;
            end
        endcase
    end

    assign mode_o = state_q;

    p_scl_low_enters_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == LINK_DDC1 && !scl_i && !clr_i) |=> mode_o == LINK_PROBE);

    p_locked_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == LINK_LOCKED && !clr_i) |=> mode_o == LINK_LOCKED);

    p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> mode_o == LINK_DDC1);

    p_scl_low_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == LINK_PROBE && !scl_i && !clr_i) |=> mode_o != LINK_DDC1);
endmodule

// File: rtl/ddc1_link_tx.sv
module ddc1_link_tx
    import ddc1_link_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int EXIT_PULSES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    input  logic              scl_i,
    input  logic              buf_wr_i,
    input  logic [DATA_W-1:0] buf_wdata_i,
    input  logic              addr_valid_i,
    input  logic              soft_rst_i,
    output logic              sda_pull_o,
    output logic              buf_empty_irq_o,
    output logic              ddc2b_o,
    output logic [1:0]        link_mode_o
);
    logic       vs_rise, tx_bit, buf_empty, one_wire;
    link_mode_e mode;

    ddc1_vsync_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .vsync_i (vsync_i),
        .rise_o  (vs_rise)
    );

    ddc1_mode_fsm #(.EXIT_PULSES(EXIT_PULSES)) u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (soft_rst_i),
        .scl_i        (scl_i),
        .rise_i       (vs_rise),
        .addr_valid_i (addr_valid_i),
        .mode_o       (mode)
    );

    assign one_wire = (mode == LINK_DDC1);

    ddc1_frame_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (soft_rst_i),
        .step_i   (vs_rise & one_wire),
        .wr_i     (buf_wr_i),
        .wdata_i  (buf_wdata_i),
        .tx_bit_o (tx_bit),
        .empty_o  (buf_empty)
    );

    always_comb begin
        sda_pull_o      = one_wire & ~tx_bit;
        buf_empty_irq_o = one_wire & buf_empty;
        ddc2b_o         = ~one_wire;
        link_mode_o     = mode;
    end

    p_sda_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ddc2b_o |-> !sda_pull_o);

    p_no_irq_two_wire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ddc2b_o |-> !buf_empty_irq_o);
endmodule

// File: tb/ddc1_link_tx_tb_top.sv
`timescale 1ns/1ps
module ddc1_link_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsync = 1'b0, scl = 1'b1, wr = 1'b0, addr_ok = 1'b0, srst = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       sda_pull, irq, ddc2b;
    logic [1:0] mode;

    int    n_checks = 0, n_errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    ddc1_link_tx dut_i (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .scl_i(scl),
        .buf_wr_i(wr), .buf_wdata_i(wdata), .addr_valid_i(addr_ok),
        .soft_rst_i(srst), .sda_pull_o(sda_pull), .buf_empty_irq_o(irq),
        .ddc2b_o(ddc2b), .link_mode_o(mode)
    );

    // Behavioural reference model: a queue of pending line bits.
    bit         bitq[$];
    int         m_mode, m_cnt;
    logic [7:0] m_buf;
    bit         m_empty, m_tx, m_vsp;

    function automatic void load_frame(logic [7:0] b);
        for (int i = 7; i >= 0; i--) bitq.push_back(b[i]);
        bitq.push_back(1'b1);
    endfunction

    function automatic void model_init();
        bitq.delete();
        load_frame(8'hFF);
        m_mode = 0; m_cnt = 0; m_buf = 8'hFF; m_empty = 1; m_tx = 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            model_init();
            m_vsp = 1;
        end else begin
            bit         rise;
            logic [7:0] old_buf;
            int         nmode;
            rise    = vsync && !m_vsp;
            m_vsp   = vsync;
            if (srst) begin
                model_init();
            end else begin
                old_buf = m_buf;
                nmode   = m_mode;
                if (m_mode == 0 && rise) begin
                    m_tx = bitq.pop_front();
                    if (bitq.size() == 0) begin
                        load_frame(old_buf);
                        m_empty = 1;
                    end
                end
                if (wr) begin m_buf = wdata; m_empty = 0; end
                if (m_mode == 0) begin
                    m_cnt = 0;
                    if (!scl) nmode = 1;
                end else if (m_mode == 1) begin
                    if (addr_ok) begin nmode = 2; m_cnt = 0; end
                    else if (!scl) m_cnt = 0;
                    else if (rise) begin
                        m_cnt++;
                        if (m_cnt == 128) begin nmode = 0; m_cnt = 0; end
                    end
                end
                m_mode = nmode;
            end
        end
    end

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare against the model on every clock.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "model sda_pull", {7'b0, sda_pull}, {7'b0, (m_mode == 0) && !m_tx});
            chk(cur_req, "model irq", {7'b0, irq}, {7'b0, (m_mode == 0) && m_empty});
            chk(cur_req, "model ddc2b", {7'b0, ddc2b}, {7'b0, m_mode != 0});
            chk(cur_req, "model mode", {6'b0, mode}, 8'(m_mode));
        end
    end

    task automatic pulse();
        @(negedge clk) vsync = 1'b1;
        @(negedge clk) vsync = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_byte(logic [7:0] d);
        @(negedge clk) begin wr = 1'b1; wdata = d; end
        @(negedge clk) wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", "reset mode", {6'b0, mode}, 8'h00);
        chk("R1", "reset ddc2b", {7'b0, ddc2b}, 8'h00);
        chk("R1", "reset sda", {7'b0, sda_pull}, 8'h00);
        chk("R1", "reset irq", {7'b0, irq}, 8'h01);

        // R6: unwritten buffer keeps SDA released
        cur_req = "R6";
        for (int i = 0; i < 9; i++) begin
            pulse();
            chk("R6", "FF frame sda", {7'b0, sda_pull}, 8'h00);
        end

        // R5: write clears the empty flag
        cur_req = "R5";
        write_byte(8'hA5);
        chk("R5", "irq after write", {7'b0, irq}, 8'h00);

        // R4: the ninth edge reloads and flags empty
        cur_req = "R4";
        for (int i = 0; i < 9; i++) pulse();
        chk("R4", "irq at reload", {7'b0, irq}, 8'h01);
        write_byte(8'h00);

        // R2: A5 shifted MSB first
        cur_req = "R2";
        for (int i = 7; i >= 0; i--) begin
            logic [7:0] bexp;
            bexp = 8'hA5;
            pulse();
            chk("R2", "data bit", {7'b0, sda_pull}, {7'b0, ~bexp[i]});
        end
        cur_req = "R3";
        pulse();
        chk("R3", "null bit", {7'b0, sda_pull}, 8'h00);
        cur_req = "R2";
        pulse();
        chk("R2", "first bit of 00", {7'b0, sda_pull}, 8'h01);

        // R7 / R11: SCL low enters two-wire mode, SDA released
        cur_req = "R7";
        @(negedge clk) scl = 1'b0;
        @(negedge clk);
        chk("R7", "ddc2b set", {7'b0, ddc2b}, 8'h01);
        chk("R7", "no irq", {7'b0, irq}, 8'h00);
        chk("R11", "sda released", {7'b0, sda_pull}, 8'h00);
        scl = 1'b1;

        // R8: 128-edge exit window, restarted by SCL low
        cur_req = "R8";
        for (int i = 0; i < 127; i++) pulse();
        chk("R8", "still two-wire at 127", {6'b0, mode}, 8'h01);
        @(negedge clk) scl = 1'b0;
        @(negedge clk) scl = 1'b1;
        for (int i = 0; i < 127; i++) pulse();
        chk("R8", "count restarted", {6'b0, mode}, 8'h01);
        pulse();
        chk("R8", "exit after 128", {6'b0, mode}, 8'h00);
        chk("R9", "shifter held", {7'b0, sda_pull}, 8'h01);

        // R9: address match locks
        cur_req = "R9";
        @(negedge clk) scl = 1'b0;
        @(negedge clk) begin scl = 1'b1; addr_ok = 1'b1; end
        @(negedge clk) addr_ok = 1'b0;
        chk("R9", "locked", {6'b0, mode}, 8'h02);
        for (int i = 0; i < 140; i++) begin
            pulse();
            if (i % 20 == 0) begin
                @(negedge clk) scl = 1'b0;
                @(negedge clk) scl = 1'b1;
            end
        end
        chk("R9", "still locked", {6'b0, mode}, 8'h02);

        // R10: soft reset held, then released
        cur_req = "R10";
        @(negedge clk) srst = 1'b1;
        pulse();
        @(negedge clk);
        chk("R10", "held mode", {6'b0, mode}, 8'h00);
        chk("R10", "held irq", {7'b0, irq}, 8'h01);
        @(negedge clk) srst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            pulse();
            chk("R10", "FF after soft reset", {7'b0, sda_pull}, 8'h00);
        end

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule